// File: doc/BRIEF.md
# Stereo 128x Audio Interpolation Chain

This block takes one stereo pair of 20-bit signed audio samples per input period and produces a 24-bit signed stereo stream at 128 times that rate. The stream feeds a one-bit noise-shaping modulator. The rate increase has two stages. A four-phase polyphase FIR raises the rate by exactly 4 and removes the baseband images that sit at multiples of the input rate. A zero-order hold then repeats each filtered value on 32 consecutive output strobes. The images that remain near multiples of 128 times the input rate are left to filtering after the block.

The master clock runs at 256, 384 or 512 times the input rate. The block works out which of these applies by counting clocks between input strobes, and divides the master clock by 2, 3 or 4 to make the output strobe. It starts a fresh strobe train on every input strobe, so each input period carries exactly 128 output strobes. One multiply-accumulate unit serves both channels. It computes all eight phase results (two channels × four phases) serially while the previous set is being played out. That costs one input period of latency.

Top module: `interp128_chain`

## Requirements
- R1: After reset `out_strobe` stays low and both outputs read zero until the first `in_valid`. The period that starts at the first `in_valid` plays out all-zero values.
- R2: `out_strobe` pulses in the cycle after the edge that samples `in_valid`, and then once every DIV clocks. The outputs change only together with a strobe and hold their value between strobes.
- R3: An input period of exactly 128·DIV clocks holds exactly 128 strobes. A longer period stops after 128 strobes. A shorter one ends its train early.
- R4: The period P is counted in clocks between two consecutive `in_valid` edges. DIV is 2 for P < 320, 3 for 320 ≤ P < 448, and 4 otherwise. The new DIV applies from the `in_valid` that closes the measured period. Until the second `in_valid`, DIV is 2.
- R5: Each 20-bit input is placed in the upper bits of a 24-bit word, so its value is multiplied by 16. A constant input settles to that scaled value on all four phases.
- R6: Let the strobes of a period be numbered j = 0..127 in order. The strobes of the period that begins at input n+1 carry phase k = j/32. Phase k is floor(Σ c_k[t]·h_t / 128), where h0 is the newest scaled sample (input n), h1 is input n−1, h2 is input n−2 and h3 is input n−3. The coefficients (c[t0], c[t1], c[t2], c[t3]) are: k0 (0,0,128,0); k1 (−3,29,111,−9); k2 (−8,72,72,−8); k3 (−9,111,29,−3).
- R7: A phase result above 8388607 outputs 8388607 (0x7FFFFF). A result below −8388608 outputs −8388608 (0x800000). No result wraps.
- R8: Reset clears the sample history to zero. Results computed before four inputs have arrived use zero for the missing samples.
- R9: The left and right channels are filtered independently. Each output depends only on its own input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock (256, 384 or 512 × input rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | One-cycle strobe per input sample pair |
| in_left | input | 20 | Left input sample, signed |
| in_right | input | 20 | Right input sample, signed |
| out_strobe | output | 1 | Output sample strobe, 128 per input period |
| out_left | output | 24 | Left output sample, signed |
| out_right | output | 24 | Right output sample, signed |

## Verification
The bench changes the input period among 256, 384, 512, 300 and 700 clocks. A wrong ratio decision or a divider that does not realign then shows up as a strobe count other than 128, or as strobes landing off the DIV grid. A train that did not stop would show 175 strobes in a 700-clock period. The bench sends an impulse and a constant to expose a swapped phase, a swapped tap or a lost scale factor. A just-filled history shows whether reset really cleared old samples. An alternating full-scale pattern drives the sum past both limits, and an output that wraps instead of clamping flips sign there. The right channel is held at a different value from the left throughout, so any crosstalk between channels in the shared multiplier is caught.

// File: rtl/interp_pkg.sv
package interp_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int IN_W       = 20;
    localparam int OUT_W      = 24;
    localparam int NPH        = 4;
    localparam int NTAP       = 4;
    localparam int NCH        = 2;
    localparam int COEF_W     = 9;
    localparam int COEF_SHIFT = 7;
    localparam int STROBES    = 128;
    localparam int PER_W      = 12;
    localparam int DIV_W      = 3;
    localparam int PH_W       = $clog2(NPH);
    localparam int TAP_W      = $clog2(NTAP);

    // Cubic interpolation kernel sampled at quarter steps, scaled by 128.
    // Tap 0 is the newest sample; the point lies between taps 2 and 1.
    function automatic logic signed [COEF_W-1:0] coef(input logic [PH_W-1:0] ph,
                                                      input logic [TAP_W-1:0] tap);
        logic signed [COEF_W-1:0] c;
        case ({ph, tap})
            4'b00_10: c = 9'sd128;
            4'b01_00: c = -9'sd3;
            4'b01_01: c = 9'sd29;
            4'b01_10: c = 9'sd111;
            4'b01_11: c = -9'sd9;
            4'b10_00: c = -9'sd8;
            4'b10_01: c = 9'sd72;
            4'b10_10: c = 9'sd72;
            4'b10_11: c = -9'sd8;
            4'b11_00: c = -9'sd9;
            4'b11_01: c = 9'sd111;
            4'b11_10: c = 9'sd29;
            4'b11_11: c = -9'sd3;
            default:  c = '0;
        endcase
        return c;
    endfunction
endpackage

// File: rtl/rate_divider.sv
module rate_divider
    import interp_pkg::*;
#(
    parameter int STROBES_P = STROBES,
    parameter int PER_W_P   = PER_W,
    parameter int DIV_INIT  = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    output logic            fire_o,
    output logic [PH_W-1:0] phase_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int TICK_W   = $clog2(STROBES_P) + 1;
    localparam int TICK_SH  = $clog2(STROBES_P);
    localparam int HOLD_SH  = $clog2(STROBES_P / NPH);
    localparam int PW1      = PER_W_P + 1;
    localparam logic [TICK_W-1:0] TICK_END = TICK_W'(STROBES_P);
    localparam logic [TICK_W-1:0] TICK_ONE = TICK_W'(1);
    localparam logic [DIV_W-1:0]  DIV_ONE  = DIV_W'(1);
    localparam logic [DIV_W-1:0]  DIV_LO   = DIV_W'(2);
    localparam logic [DIV_W-1:0]  DIV_MID  = DIV_W'(3);
    localparam logic [DIV_W-1:0]  DIV_HI   = DIV_W'(4);
    localparam logic [DIV_W-1:0]  DIV_RST  = DIV_W'(DIV_INIT);
    localparam logic [PW1-1:0]    TH_LO    = PW1'(STROBES_P * 5 / 2);
    localparam logic [PW1-1:0]    TH_HI    = PW1'(STROBES_P * 7 / 2);

    typedef struct packed {
        logic               started;
        logic [DIV_W-1:0]   div;
        logic [DIV_W-1:0]   cnt;
        logic [TICK_W-1:0]  tick;
        logic [PER_W_P-1:0] per;
    } rd_state_t;

    rd_state_t s_q, s_d;
    logic           fire_run;
    logic [PW1-1:0] period;
    logic [PW1-1:0] full_len;

    always_comb begin
        s_d      = s_q;
        period   = {1'b0, s_q.per} + PW1'(1);
        full_len = PW1'(s_q.div) << TICK_SH;
        fire_run = s_q.started && (s_q.tick < TICK_END) && (s_q.cnt == s_q.div - DIV_ONE);
        fire_o   = load_i | fire_run;
        phase_o  = load_i ? '0 : s_q.tick[HOLD_SH +: PH_W];

        if (s_q.per != '1) begin
            s_d.per = s_q.per + PER_W_P'(1);
        end

        if (load_i) begin
            s_d.started = 1'b1;
            s_d.cnt     = '0;
            s_d.tick    = TICK_ONE;
            s_d.per     = '0;
            if (s_q.started) begin
                if (period < TH_LO) begin
                    s_d.div = DIV_LO;
                end else if (period < TH_HI) begin
                    s_d.div = DIV_MID;
                end else begin
                    s_d.div = DIV_HI;
                end
            end
        end else if (fire_run) begin
            s_d.cnt  = '0;
            s_d.tick = s_q.tick + TICK_ONE;
        end else if (s_q.tick < TICK_END) begin
            s_d.cnt = s_q.cnt + DIV_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{started: 1'b0, div: DIV_RST, cnt: '0, tick: '0, per: '0};
        end else begin
            s_q <= s_d;
        end
    end

    // R3: a period of exactly 128*DIV clocks must have delivered a full train
    assert_full_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && s_q.started && (period == full_len)) |-> (s_q.tick == TICK_END));

    // R4: the divide ratio stays within the three supported settings
    assert_div_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.div >= DIV_LO) && (s_q.div <= DIV_HI));
endmodule

// File: rtl/poly_mac.sv
module poly_mac
    import interp_pkg::*;
#(
    parameter int IN_W_P  = IN_W,
    parameter int OUT_W_P = OUT_W
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            load_i,
    input  logic signed [IN_W_P-1:0]        in_l_i,
    input  logic signed [IN_W_P-1:0]        in_r_i,
    output logic [NPH-1:0][OUT_W_P-1:0]     pend_l_o,
    output logic [NPH-1:0][OUT_W_P-1:0]     pend_r_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int STEPS   = NCH * NPH * NTAP;
    localparam int IDX_W   = $clog2(STEPS);
    localparam int PAD     = OUT_W_P - IN_W_P;
    localparam int ACC_W_L = OUT_W_P + COEF_W + TAP_W;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(STEPS - 1);
    localparam logic [TAP_W-1:0] TAP_LAST = TAP_W'(NTAP - 1);
    localparam logic signed [ACC_W_L-1:0] ACC_ZERO = '0;
    localparam logic signed [ACC_W_L-1:0] SAT_HI   = ACC_W_L'((64'sd1 <<< (OUT_W_P - 1)) - 64'sd1);
    localparam logic signed [ACC_W_L-1:0] SAT_LO   = -SAT_HI - ACC_W_L'(1);

    typedef struct packed {
        logic [NCH-1:0][NTAP-1:0][OUT_W_P-1:0] hist;
        logic [NCH-1:0][NPH-1:0][OUT_W_P-1:0]  pend;
        logic                                  busy;
        logic [IDX_W-1:0]                      idx;
        logic signed [ACC_W_L-1:0]             acc;
    } mac_state_t;

    mac_state_t s_q, s_d;

    logic                      ch;
    logic [PH_W-1:0]           ph;
    logic [TAP_W-1:0]          tap;
    logic signed [OUT_W_P-1:0] smp;
    logic signed [COEF_W-1:0]  cf;
    logic signed [ACC_W_L-1:0] prod;
    logic signed [ACC_W_L-1:0] sum;
    logic [OUT_W_P-1:0]        ext_l, ext_r;

    function automatic logic [OUT_W_P-1:0] clamp_out(input logic signed [ACC_W_L-1:0] a);
        logic signed [ACC_W_L-1:0] sh;
        sh = a >>> COEF_SHIFT;
        if (sh > SAT_HI) begin
            return SAT_HI[OUT_W_P-1:0];
        end else if (sh < SAT_LO) begin
            return SAT_LO[OUT_W_P-1:0];
        end
        return sh[OUT_W_P-1:0];
    endfunction

    always_comb begin
        s_d   = s_q;
        ch    = s_q.idx[IDX_W-1];
        ph    = s_q.idx[TAP_W +: PH_W];
        tap   = s_q.idx[TAP_W-1:0];
        smp   = $signed(s_q.hist[ch][tap]);
        cf    = coef(ph, tap);
        prod  = ACC_W_L'(smp) * ACC_W_L'(cf);
        sum   = ((tap == '0) ? ACC_ZERO : s_q.acc) + prod;
        ext_l = {in_l_i, {PAD{1'b0}}};
        ext_r = {in_r_i, {PAD{1'b0}}};

        if (load_i) begin
            s_d.hist[0] = {s_q.hist[0][NTAP-2:0], ext_l};
            s_d.hist[1] = {s_q.hist[1][NTAP-2:0], ext_r};
            s_d.busy    = 1'b1;
            s_d.idx     = '0;
        end else if (s_q.busy) begin
            s_d.acc = sum;
            if (tap == TAP_LAST) begin
                s_d.pend[ch][ph] = clamp_out(sum);
            end
            s_d.idx = s_q.idx + IDX_W'(1);
            if (s_q.idx == IDX_LAST) begin
                s_d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pend_l_o = s_q.pend[0];
    assign pend_r_o = s_q.pend[1];

    // R6: every new sample starts a complete pass over both channels
    assert_mac_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (s_q.busy && (s_q.idx == '0)));

    // R6: the pass ends after the last phase of the second channel
    assert_mac_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && (s_q.idx == IDX_LAST) && !load_i) |=> !s_q.busy);
endmodule

// File: rtl/hold_stage.sv
module hold_stage
    import interp_pkg::*;
#(
    parameter int OUT_W_P = OUT_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load_i,
    input  logic                        fire_i,
    input  logic [PH_W-1:0]             phase_i,
    input  logic [NPH-1:0][OUT_W_P-1:0] pend_l_i,
    input  logic [NPH-1:0][OUT_W_P-1:0] pend_r_i,
    output logic                        strobe_o,
    output logic [OUT_W_P-1:0]          out_l_o,
    output logic [OUT_W_P-1:0]          out_r_o
);
    timeunit 1ns;
    timeprecision 1ps;

    typedef struct packed {
        logic [NPH-1:0][OUT_W_P-1:0] act_l;
        logic [NPH-1:0][OUT_W_P-1:0] act_r;
        logic                        strobe;
        logic [OUT_W_P-1:0]          val_l;
        logic [OUT_W_P-1:0]          val_r;
    } hold_state_t;

    hold_state_t s_q, s_d;
    logic [NPH-1:0][OUT_W_P-1:0] src_l, src_r;

    always_comb begin
        s_d      = s_q;
        src_l    = load_i ? pend_l_i : s_q.act_l;
        src_r    = load_i ? pend_r_i : s_q.act_r;
        s_d.strobe = fire_i;
        if (load_i) begin
            s_d.act_l = pend_l_i;
            s_d.act_r = pend_r_i;
        end
        if (fire_i) begin
            s_d.val_l = src_l[phase_i];
            s_d.val_r = src_r[phase_i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign strobe_o = s_q.strobe;
    assign out_l_o  = s_q.val_l;
    assign out_r_o  = s_q.val_r;

    // R2: every input sample opens a strobe train at once
    assert_load_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> strobe_o);

    // R2: outputs only move together with a strobe
    assert_hold_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !fire_i |=> ($stable(out_l_o) && $stable(out_r_o)));
endmodule

// File: rtl/interp128_chain.sv
module interp128_chain
    import interp_pkg::*;
#(
    parameter int IN_W_P    = IN_W,
    parameter int OUT_W_P   = OUT_W,
    parameter int STROBES_P = STROBES,
    parameter int DIV_INIT  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [IN_W_P-1:0] in_left,
    input  logic signed [IN_W_P-1:0] in_right,
    output logic                     out_strobe,
    output logic [OUT_W_P-1:0]       out_left,
    output logic [OUT_W_P-1:0]       out_right
);
    timeunit 1ns;
    timeprecision 1ps;

    logic                        fire;
    logic [PH_W-1:0]             phase;
    logic [NPH-1:0][OUT_W_P-1:0] pend_l, pend_r;

    rate_divider #(
        .STROBES_P (STROBES_P),
        .PER_W_P   (PER_W),
        .DIV_INIT  (DIV_INIT)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (in_valid),
        .fire_o  (fire),
        .phase_o (phase)
    );

    poly_mac #(
        .IN_W_P  (IN_W_P),
        .OUT_W_P (OUT_W_P)
    ) u_mac (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (in_valid),
        .in_l_i   (in_left),
        .in_r_i   (in_right),
        .pend_l_o (pend_l),
        .pend_r_o (pend_r)
    );

    hold_stage #(
        .OUT_W_P (OUT_W_P)
    ) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (in_valid),
        .fire_i   (fire),
        .phase_i  (phase),
        .pend_l_i (pend_l),
        .pend_r_i (pend_r),
        .strobe_o (out_strobe),
        .out_l_o  (out_left),
        .out_r_o  (out_right)
    );
endmodule

// File: tb/interp128_chain_tb_top.sv
module interp128_chain_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic signed [19:0] in_left = '0;
    logic signed [19:0] in_right = '0;
    logic               out_strobe;
    logic signed [23:0] out_left;
    logic signed [23:0] out_right;

    interp128_chain dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_left    (in_left),
        .in_right   (in_right),
        .out_strobe (out_strobe),
        .out_left   (out_left),
        .out_right  (out_right)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    int cf [4][4] = '{'{0, 0, 128, 0}, '{-3, 29, 111, -9},
                      '{-8, 72, 72, -8}, '{-9, 111, 29, -3}};

    logic signed [23:0] bh_l [4];
    logic signed [23:0] bh_r [4];
    logic signed [23:0] pn_l [4];
    logic signed [23:0] pn_r [4];
    logic signed [23:0] ac_l [4];
    logic signed [23:0] ac_r [4];
    logic signed [23:0] obs_l [4];
    logic signed [23:0] obs_r [4];
    logic signed [23:0] exp_l, exp_r;
    int n_samp = 0;
    int prev_p = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic logic signed [23:0] model(input logic signed [23:0] h [4], input int ph);
        longint acc = 0;
        for (int t = 0; t < 4; t++) acc += longint'(h[t]) * cf[ph][t];
        acc = acc >>> 7;
        if (acc > 8388607) acc = 8388607;
        if (acc < -8388608) acc = -8388608;
        return acc[23:0];
    endfunction

    function automatic int pick_div(input int p);
        if (p < 320) return 2;
        if (p < 448) return 3;
        return 4;
    endfunction

    // One input period of P clocks; starts and ends on a falling edge.
    task automatic run_sample(input int P, input logic signed [19:0] l,
                              input logic signed [19:0] r, input string tag);
        int div, cnt, bad, pos_bad, exp_cnt;
        longint bad_act, bad_exp;
        div = (n_samp == 0) ? 2 : pick_div(prev_p);
        for (int k = 0; k < 4; k++) begin
            ac_l[k] = pn_l[k];
            ac_r[k] = pn_r[k];
        end
        for (int k = 3; k > 0; k--) begin
            bh_l[k] = bh_l[k-1];
            bh_r[k] = bh_r[k-1];
        end
        bh_l[0] = {l, 4'b0};
        bh_r[0] = {r, 4'b0};
        for (int k = 0; k < 4; k++) begin
            pn_l[k] = model(bh_l, k);
            pn_r[k] = model(bh_r, k);
        end
        in_valid = 1'b1;
        in_left  = l;
        in_right = r;
        cnt = 0; bad = 0; pos_bad = 0; bad_act = 0; bad_exp = 0;
        for (int c = 0; c < P; c++) begin
            @(negedge clk);
            if (c == 0) in_valid = 1'b0;
            if (out_strobe) begin
                if ((c % div) != 0 || cnt >= 128) pos_bad++;
                if (cnt < 128) begin
                    exp_l = ac_l[cnt / 32];
                    exp_r = ac_r[cnt / 32];
                    obs_l[cnt / 32] = out_left;
                    obs_r[cnt / 32] = out_right;
                end
                cnt++;
            end
            if (out_left !== exp_l || out_right !== exp_r) begin
                if (bad == 0) begin
                    bad_act = (out_left !== exp_l) ? longint'(out_left) : longint'(out_right);
                    bad_exp = (out_left !== exp_l) ? longint'(exp_l) : longint'(exp_r);
                end
                bad++;
            end
        end
        exp_cnt = ((P - 1) / div) + 1;
        if (exp_cnt > 128) exp_cnt = 128;
        chk(cnt == exp_cnt, {"R3 R4 strobe count ", tag}, cnt, exp_cnt);
        chk(pos_bad == 0, {"R2 strobe spacing ", tag}, pos_bad, 0);
        chk(bad == 0, {"R6 R9 output values ", tag}, bad_act, bad_exp);
        prev_p = P;
        n_samp++;
    endtask

    task automatic t_reset();
        int bad = 0;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (out_strobe !== 1'b0 || out_left !== 24'sd0 || out_right !== 24'sd0) bad++;
        end
        chk(bad == 0, "R1 idle after reset", bad, 0);
    endtask

    task automatic t_warmup();
        run_sample(256, 20'sd1000, -20'sd1000, "first");
        chk(obs_l[0] == 0 && obs_l[3] == 0, "R1 first period zero", obs_l[3], 0);
        run_sample(256, 20'sd0, 20'sd0, "second");
        chk(obs_l[3] == -24'sd1125, "R8 cleared history phase3", obs_l[3], -1125);
        chk(obs_l[0] == 24'sd0, "R8 cleared history phase0", obs_l[0], 0);
    endtask

    task automatic t_const();
        for (int i = 0; i < 5; i++) run_sample(256, 20'sd12345, -20'sd54321, "const");
        for (int k = 0; k < 4; k++) begin
            chk(obs_l[k] == 24'sd197520, "R5 const left scaled", obs_l[k], 197520);
            chk(obs_r[k] == -24'sd869136, "R5 R9 const right scaled", obs_r[k], -869136);
        end
    endtask

    task automatic t_impulse();
        for (int i = 0; i < 4; i++) run_sample(256, 20'sd0, 20'sd0, "flush");
        run_sample(256, 20'sd100000, 20'sd0, "impulse");
        run_sample(256, 20'sd0, 20'sd0, "imp h0");
        run_sample(256, 20'sd0, 20'sd0, "imp h1");
        chk(obs_l[1] == 24'sd362500, "R6 impulse tap h1 phase1", obs_l[1], 362500);
        chk(obs_r[1] == 24'sd0, "R9 right untouched", obs_r[1], 0);
        run_sample(256, 20'sd0, 20'sd0, "imp h2");
        chk(obs_l[0] == 24'sd1600000, "R6 impulse tap h2 phase0", obs_l[0], 1600000);
        run_sample(256, 20'sd0, 20'sd0, "imp h3");
    endtask

    task automatic t_ratio();
        for (int i = 0; i < 3; i++) run_sample(384, 20'sd2000 * i, -20'sd3000, "ratio384");
        for (int i = 0; i < 3; i++) run_sample(512, -20'sd4000, 20'sd700 * i, "ratio512");
        run_sample(300, 20'sd10, 20'sd20, "ratio300");
        run_sample(256, 20'sd30, 20'sd40, "back256");
        run_sample(256, 20'sd50, 20'sd60, "steady256");
    endtask

    task automatic t_long();
        run_sample(700, 20'sd111, 20'sd222, "long a");
        run_sample(700, 20'sd333, 20'sd444, "long b");
        run_sample(512, 20'sd555, 20'sd666, "after long");
    endtask

    task automatic t_sat();
        run_sample(256, -20'sd524288, 20'sd524287, "sat0");
        run_sample(256, 20'sd524287, -20'sd524288, "sat1");
        run_sample(256, 20'sd524287, -20'sd524288, "sat2");
        run_sample(256, -20'sd524288, 20'sd524287, "sat3");
        run_sample(256, 20'sd0, 20'sd0, "sat out");
        chk(obs_l[1] == 24'sd8388607, "R7 positive clamp", obs_l[1], 8388607);
        chk(obs_r[1] == -24'sd8388608, "R7 negative clamp", obs_r[1], -8388608);
        chk(obs_l[2] == 24'sd8388607, "R7 positive clamp phase2", obs_l[2], 8388607);
        run_sample(256, 20'sd0, 20'sd0, "sat end");
    endtask

    initial begin
        for (int k = 0; k < 4; k++) begin
            bh_l[k] = '0; bh_r[k] = '0; pn_l[k] = '0; pn_r[k] = '0;
            ac_l[k] = '0; ac_r[k] = '0; obs_l[k] = '0; obs_r[k] = '0;
        end
        exp_l = '0;
        exp_r = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_warmup();
        t_const();
        t_impulse();
        t_ratio();
        t_long();
        t_sat();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule